// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block arbitrates among 256 numbered interrupt vectors for a single processor. Three 256-bit state vectors are held: pending requests, vectors currently being serviced, and a trigger-mode flag per vector. Any number may be pending or in service at once. A larger vector number always means higher urgency. Vectors fall into classes of sixteen, and the class is the upper nibble of the vector number.

A processor priority level is formed from the task priority register and the class of the most urgent vector in service. The interrupt line is raised when software has enabled the block and the most urgent pending request belongs to a class above that level. An acknowledge strobe returns a vector in the same cycle, and at the clock edge that vector moves from pending to in service. If the request does not clear the task priority, the low byte of the spurious register is returned and no state changes. An end-of-interrupt strobe retires the most urgent vector in service.

Top module: `vic_ctrl`

## Requirements
- R1: After reset the task priority reads 0, the spurious register reads 0x0FF, no vector is pending or in service, `irq_o` is 0, `ppr_o` is 0 and an acknowledge reports `ack_none_o`.
- R2: Among pending requests, the one with the largest vector number is the one that an acknowledge returns.
- R3: `ppr_o` equals `tpr_o` when `tpr_o[7:4]` is at least the class (bits 7:4) of the largest in-service vector, or when nothing is in service. Otherwise it equals that class shifted left by 4, with the low nibble 0.
- R4: `irq_o` is 1 only when `spur_o[8]` is 1, a request is pending, and either `ppr_o` is 0 or bits 7:4 of the largest pending vector exceed `ppr_o[7:4]`.
- R5: During acknowledge, if `tpr_o` is nonzero and the largest pending vector is at or below `tpr_o`, then `ack_spur_o` is 1 and `ack_vec_o` equals `spur_o[7:0]`. Pending and in-service state do not change.
- R6: Otherwise, during acknowledge with a request pending, `ack_vec_o` is that request. At the clock edge its pending bit clears and its in-service bit sets.
- R7: An acknowledge with nothing pending sets `ack_none_o` to 1 and `ack_vec_o` to 0. No state changes.
- R8: End-of-interrupt clears only the largest in-service vector. With nothing in service it has no effect.
- R9: A request with `req_level_i` 1 sets that vector's trigger flag, and with 0 it clears it. `isr_top_level_o` shows the flag of the largest in-service vector.
- R10: A spurious-register write keeps bits 8:0 of the data and drops the rest. A task-priority write stores all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Raise a request this cycle |
| req_vec_i | input | 8 | Vector of the request |
| req_level_i | input | 1 | 1 for a level-triggered request, 0 for edge |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vec_o | output | 8 | Vector returned by acknowledge |
| ack_spur_o | output | 1 | Acknowledge would return the spurious vector |
| ack_none_o | output | 1 | Nothing is pending |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_we_i | input | 1 | Task priority write enable |
| tpr_wdata_i | input | 8 | Task priority write data |
| spur_we_i | input | 1 | Spurious register write enable |
| spur_wdata_i | input | 16 | Spurious register write data |
| irq_o | output | 1 | Interrupt line to the processor |
| ppr_o | output | 8 | Processor priority |
| tpr_o | output | 8 | Task priority register |
| spur_o | output | 9 | Spurious register; bit 8 is the software enable |
| isr_top_valid_o | output | 1 | At least one vector is in service |
| isr_top_vec_o | output | 8 | Largest vector in service |
| isr_top_level_o | output | 1 | Trigger flag of that vector |

## Verification
A wrong bit in the pending or in-service vectors shows up at once on the combinational outputs. `irq_o`, `ppr_o` and `isr_top_vec_o` change in the cycle after the faulty update, and an acknowledge returns the wrong vector in that same cycle. A wrong trigger flag shows only when its vector becomes the largest in service, so every vector is taken through a set, acknowledge and retire sequence with both trigger values. A sweep of the task priority class against the request class tests the irq and spurious-acknowledge thresholds at every boundary.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VIC_NUM_VEC = 256;
  localparam int unsigned VIC_CLASS_SIZE = 16;
  localparam int unsigned VIC_SPUR_IN_W = 16;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_SPUR = 2'd1,
    ACK_VEC  = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned N   = 256,
  parameter int unsigned GRP = 16
) (
  input  logic [N-1:0]          bits_i,
  output logic                  valid_o,
  output logic [$clog2(N)-1:0]  idx_o
);
  localparam int unsigned W  = $clog2(N);
  localparam int unsigned GW = $clog2(GRP);
  localparam int unsigned NG = N / GRP;
  localparam int unsigned SW = W - GW;

  function automatic logic [GW-1:0] sub_enc(input logic [GRP-1:0] b);
    logic [GW-1:0] r;
    r = '0;
    for (int i = 0; i < GRP; i++) if (b[i]) r = GW'(i);
    return r;
  endfunction

  logic [NG-1:0]    grp_any;
  logic [NG*GW-1:0] grp_sub;
  logic [SW-1:0]    sel;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g]           = |bits_i[g*GRP +: GRP];
    assign grp_sub[g*GW +: GW]  = sub_enc(bits_i[g*GRP +: GRP]);
  end

  // upper level: highest non-empty group
  always_comb begin
    sel = '0;
    for (int g = 0; g < NG; g++) if (grp_any[g]) sel = SW'(g);
  end

  assign valid_o = |grp_any;
  assign idx_o   = {sel, grp_sub[sel*GW +: GW]};
endmodule

// File: rtl/vic_vec_store.sv
module vic_vec_store #(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       set_i,
  input  logic [$clog2(NUM_VEC)-1:0] set_vec_i,
  input  logic                       set_level_i,
  input  logic                       move_i,
  input  logic [$clog2(NUM_VEC)-1:0] move_vec_i,
  input  logic                       retire_i,
  input  logic [$clog2(NUM_VEC)-1:0] retire_vec_i,
  output logic [NUM_VEC-1:0]         irr_o,
  output logic [NUM_VEC-1:0]         isr_o,
  output logic [NUM_VEC-1:0]         tmr_o
);
  logic [NUM_VEC-1:0] set_mask, move_mask, retire_mask;

  assign set_mask    = set_i    ? (NUM_VEC'(1) << set_vec_i)    : '0;
  assign move_mask   = move_i   ? (NUM_VEC'(1) << move_vec_i)   : '0;
  assign retire_mask = retire_i ? (NUM_VEC'(1) << retire_vec_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_o <= '0;
      isr_o <= '0;
      tmr_o <= '0;
    end else begin
      irr_o <= (irr_o & ~move_mask) | set_mask;
      isr_o <= (isr_o & ~retire_mask) | move_mask;
      if (set_i) tmr_o[set_vec_i] <= set_level_i;
    end
  end
endmodule

// File: rtl/vic_prio_calc.sv
module vic_prio_calc
  import vic_pkg::*;
#(
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned CLASS_SIZE = 16
) (
  input  logic             sw_en_i,
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             irr_valid_i,
  input  logic [VEC_W-1:0] irr_top_i,
  input  logic             isr_valid_i,
  input  logic [VEC_W-1:0] isr_top_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             irq_o,
  output ack_kind_e        ack_kind_o
);
  localparam int unsigned CL = $clog2(CLASS_SIZE);
  localparam int unsigned CW = VEC_W - CL;

  logic [CW-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

  assign tpr_cls = tpr_i[VEC_W-1:CL];
  assign isr_cls = isr_valid_i ? isr_top_i[VEC_W-1:CL] : '0;
  assign irr_cls = irr_top_i[VEC_W-1:CL];

  assign ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {CL{1'b0}}};
  assign ppr_cls = ppr_o[VEC_W-1:CL];

  assign irq_o = sw_en_i && irr_valid_i && ((ppr_o == '0) || (irr_cls > ppr_cls));

  always_comb begin
    if (!irr_valid_i)                                ack_kind_o = ACK_NONE;
    else if ((tpr_i != '0) && (irr_top_i <= tpr_i)) ack_kind_o = ACK_SPUR;
    else                                             ack_kind_o = ACK_VEC;
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_VEC    = VIC_NUM_VEC,
  parameter int unsigned CLASS_SIZE = VIC_CLASS_SIZE,
  parameter int unsigned SPUR_IN_W  = VIC_SPUR_IN_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [$clog2(NUM_VEC)-1:0] req_vec_i,
  input  logic                       req_level_i,
  input  logic                       ack_i,
  output logic [$clog2(NUM_VEC)-1:0] ack_vec_o,
  output logic                       ack_spur_o,
  output logic                       ack_none_o,
  input  logic                       eoi_i,
  input  logic                       tpr_we_i,
  input  logic [$clog2(NUM_VEC)-1:0] tpr_wdata_i,
  input  logic                       spur_we_i,
  input  logic [SPUR_IN_W-1:0]       spur_wdata_i,
  output logic                       irq_o,
  output logic [$clog2(NUM_VEC)-1:0] ppr_o,
  output logic [$clog2(NUM_VEC)-1:0] tpr_o,
  output logic [$clog2(NUM_VEC):0]   spur_o,
  output logic                       isr_top_valid_o,
  output logic [$clog2(NUM_VEC)-1:0] isr_top_vec_o,
  output logic                       isr_top_level_o
);
  localparam int unsigned VEC_W  = $clog2(NUM_VEC);
  localparam int unsigned SPUR_W = VEC_W + 1;
  localparam logic [SPUR_W-1:0] SPUR_RST = {1'b0, {VEC_W{1'b1}}};

  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic               irr_valid, isr_valid;
  logic [VEC_W-1:0]   irr_top, isr_top;
  ack_kind_e          ack_kind;
  logic               do_move, do_retire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_o  <= '0;
      spur_o <= SPUR_RST;
    end else begin
      if (tpr_we_i)  tpr_o  <= tpr_wdata_i;
      if (spur_we_i) spur_o <= spur_wdata_i[SPUR_W-1:0];
    end
  end

  assign do_move   = ack_i && (ack_kind == ACK_VEC);
  assign do_retire = eoi_i && isr_valid;

  vic_vec_store #(.NUM_VEC(NUM_VEC)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (req_valid_i),
    .set_vec_i   (req_vec_i),
    .set_level_i (req_level_i),
    .move_i      (do_move),
    .move_vec_i  (irr_top),
    .retire_i    (do_retire),
    .retire_vec_i(isr_top),
    .irr_o       (irr),
    .isr_o       (isr),
    .tmr_o       (tmr)
  );

  vic_prio_enc #(.N(NUM_VEC), .GRP(CLASS_SIZE)) u_irr_enc (
    .bits_i (irr),
    .valid_o(irr_valid),
    .idx_o  (irr_top)
  );

  vic_prio_enc #(.N(NUM_VEC), .GRP(CLASS_SIZE)) u_isr_enc (
    .bits_i (isr),
    .valid_o(isr_valid),
    .idx_o  (isr_top)
  );

  vic_prio_calc #(.VEC_W(VEC_W), .CLASS_SIZE(CLASS_SIZE)) u_calc (
    .sw_en_i    (spur_o[VEC_W]),
    .tpr_i      (tpr_o),
    .irr_valid_i(irr_valid),
    .irr_top_i  (irr_top),
    .isr_valid_i(isr_valid),
    .isr_top_i  (isr_top),
    .ppr_o      (ppr_o),
    .irq_o      (irq_o),
    .ack_kind_o (ack_kind)
  );

  always_comb begin
    unique case (ack_kind)
      ACK_SPUR: ack_vec_o = spur_o[VEC_W-1:0];
      ACK_VEC:  ack_vec_o = irr_top;
      default:  ack_vec_o = '0;
    endcase
  end

  assign ack_spur_o      = (ack_kind == ACK_SPUR);
  assign ack_none_o      = (ack_kind == ACK_NONE);
  assign isr_top_valid_o = isr_valid;
  assign isr_top_vec_o   = isr_valid ? isr_top : '0;
  assign isr_top_level_o = isr_valid && tmr[isr_top];
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int unsigned VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             ack_i,
  input logic             eoi_i,
  input logic [VEC_W-1:0] ack_vec_o,
  input logic             ack_spur_o,
  input logic             ack_none_o,
  input logic             irq_o,
  input logic [VEC_W-1:0] ppr_o,
  input logic [VEC_W-1:0] tpr_o,
  input logic [VEC_W:0]   spur_o,
  input logic             isr_top_valid_o,
  input logic [VEC_W-1:0] isr_top_vec_o
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> spur_o[VEC_W]); // R4

  AST_PPR_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o >= tpr_o); // R3

  AST_ACK_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_spur_o && ack_none_o)); // R7

  AST_SPUR_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_spur_o |-> ack_vec_o == spur_o[VEC_W-1:0]); // R5

  AST_SPUR_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_spur_o && !eoi_i) |=> $stable(isr_top_valid_o) && $stable(isr_top_vec_o)); // R5

  AST_ACK_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_spur_o && !ack_none_o) |=> isr_top_valid_o && (isr_top_vec_o >= $past(ack_vec_o))); // R6

  AST_EOI_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !isr_top_valid_o && !ack_i) |=> !isr_top_valid_o); // R8

  AST_NONE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_none_o |-> (ack_vec_o == '0) && !irq_o); // R7
endmodule

bind vic_ctrl vic_ctrl_chk #(.VEC_W($clog2(NUM_VEC))) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .ack_i          (ack_i),
  .eoi_i          (eoi_i),
  .ack_vec_o      (ack_vec_o),
  .ack_spur_o     (ack_spur_o),
  .ack_none_o     (ack_none_o),
  .irq_o          (irq_o),
  .ppr_o          (ppr_o),
  .tpr_o          (tpr_o),
  .spur_o         (spur_o),
  .isr_top_valid_o(isr_top_valid_o),
  .isr_top_vec_o  (isr_top_vec_o)
);

// File: tb/vic_ctrl_tb_top.sv
`timescale 1ns/1ps
module vic_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_vec = '0;
  logic       req_level = 1'b0;
  logic       ack = 1'b0;
  logic [7:0] ack_vec;
  logic       ack_spur, ack_none;
  logic       eoi = 1'b0;
  logic       tpr_we = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic       spur_we = 1'b0;
  logic [15:0] spur_wdata = '0;
  logic       irq;
  logic [7:0] ppr, tpr;
  logic [8:0] spur;
  logic       isr_v, isr_lvl;
  logic [7:0] isr_vec;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [255:0] m_irr, m_isr, m_tmr;
  logic [7:0]   m_tpr;
  logic [8:0]   m_spur;

  always #5 clk = ~clk;

  vic_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vec_i(req_vec), .req_level_i(req_level),
    .ack_i(ack), .ack_vec_o(ack_vec), .ack_spur_o(ack_spur), .ack_none_o(ack_none),
    .eoi_i(eoi), .tpr_we_i(tpr_we), .tpr_wdata_i(tpr_wdata),
    .spur_we_i(spur_we), .spur_wdata_i(spur_wdata),
    .irq_o(irq), .ppr_o(ppr), .tpr_o(tpr), .spur_o(spur),
    .isr_top_valid_o(isr_v), .isr_top_vec_o(isr_vec), .isr_top_level_o(isr_lvl)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int top_of(input logic [255:0] b);
    int r = -1;
    for (int i = 0; i < 256; i++) if (b[i]) r = i;
    return r;
  endfunction

  function automatic int exp_ppr();
    int iv = top_of(m_isr);
    int ic = (iv < 0) ? 0 : (iv >> 4);
    return (int'(m_tpr[7:4]) >= ic) ? int'(m_tpr) : (ic << 4);
  endfunction

  function automatic int exp_irq();
    int rv = top_of(m_irr);
    int p = exp_ppr();
    if (!m_spur[8] || rv < 0) return 0;
    return ((p == 0) || ((rv >> 4) > (p >> 4))) ? 1 : 0;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_state(input string tag);
    int iv;
    #1;
    iv = top_of(m_isr);
    chk({tag, " R4 irq"}, int'(irq), exp_irq());
    chk({tag, " R3 ppr"}, int'(ppr), exp_ppr());
    chk({tag, " R8 isr_valid"}, int'(isr_v), (iv >= 0) ? 1 : 0);
    if (iv >= 0) begin
      chk({tag, " R8 isr_vec"}, int'(isr_vec), iv);
      chk({tag, " R9 level"}, int'(isr_lvl), int'(m_tmr[iv]));
    end
  endtask

  task automatic do_set(input int v, input bit lvl);
    req_valid = 1'b1; req_vec = 8'(v); req_level = lvl;
    step();
    req_valid = 1'b0;
    m_irr[v] = 1'b1; m_tmr[v] = lvl;
  endtask

  task automatic do_ack(input string tag);
    int rv = top_of(m_irr);
    ack = 1'b1;
    #1;
    if (rv < 0) begin
      chk({tag, " R7 none"}, int'(ack_none), 1);
      chk({tag, " R7 vec"}, int'(ack_vec), 0);
    end else if (m_tpr != 0 && rv <= int'(m_tpr)) begin
      chk({tag, " R5 spur flag"}, int'(ack_spur), 1);
      chk({tag, " R5 spur vec"}, int'(ack_vec), int'(m_spur[7:0]));
    end else begin
      chk({tag, " R6 flags"}, int'({ack_spur, ack_none}), 0);
      chk({tag, " R2 vec"}, int'(ack_vec), rv);
      m_irr[rv] = 1'b0; m_isr[rv] = 1'b1;
    end
    step();
    ack = 1'b0;
  endtask

  task automatic do_eoi();
    int iv = top_of(m_isr);
    eoi = 1'b1;
    step();
    eoi = 1'b0;
    if (iv >= 0) m_isr[iv] = 1'b0;
  endtask

  task automatic do_tpr(input int v);
    tpr_we = 1'b1; tpr_wdata = 8'(v);
    step();
    tpr_we = 1'b0; m_tpr = 8'(v);
  endtask

  task automatic do_spur(input int v);
    spur_we = 1'b1; spur_wdata = 16'(v);
    step();
    spur_we = 1'b0; m_spur = 9'(v);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0; m_spur = 9'h0FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 tpr", int'(tpr), 0);
    chk("R1 spur", int'(spur), 'h0FF);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ppr", int'(ppr), 0);
    chk("R1 isr_valid", int'(isr_v), 0);
    chk("R1 ack_none", int'(ack_none), 1);
    do_ack("R1 empty");
    chk_state("R7 after empty ack");

    // R4: disabled block keeps irq low
    do_set(8'h80, 1'b0);
    chk_state("R4 disabled");
    do_ack("R4 disabled");
    do_eoi();
    chk_state("R4 drain");

    // R10 register writes
    do_spur('hA1F3);
    #1 chk("R10 spur mask", int'(spur), 'h1F3);
    do_tpr('hC7);
    #1 chk("R10 tpr", int'(tpr), 'hC7);
    do_tpr(0);
    do_spur('h01FF);

    // full vector sweep, alternate trigger mode
    for (int v = 0; v < 256; v++) begin
      do_set(v, v[0]);
      chk_state("R4 sweep");
      do_ack("R6 sweep");
      chk_state("R9 sweep");
      do_eoi();
      chk_state("R8 sweep");
    end

    // R2 ordering and nesting
    for (int i = 0; i < 10; i++) do_set((i * 37 + 11) % 256, i[1]);
    chk_state("R2 multi");
    for (int i = 0; i < 10; i++) begin
      do_ack("R2 order");
      chk_state("R3 nested");
    end
    for (int i = 0; i < 11; i++) begin
      do_eoi();
      chk_state("R8 pop");
    end

    // R3/R4 same-class rule
    do_set(8'h45, 1'b1);
    do_ack("R6 same class");
    do_set(8'h4A, 1'b0);
    chk_state("R4 same class");
    do_set(8'h55, 1'b0);
    chk_state("R4 higher class");
    do_ack("R2 higher"); do_ack("R2 lower");
    repeat (3) begin do_eoi(); chk_state("R8 drain"); end

    // R9 trigger override on repeated request
    do_set(8'h30, 1'b0);
    do_set(8'h30, 1'b1);
    do_ack("R9 override");
    chk_state("R9 override");
    do_eoi();

    // task priority class against request class
    for (int tc = 0; tc < 16; tc++) begin
      for (int rc = 0; rc < 16; rc++) begin
        do_tpr((tc << 4) | 5);
        do_set((rc << 4) | 3, rc[0]);
        chk_state("R4 tpr sweep");
        do_ack("R5 tpr sweep");
        chk_state("R5 tpr sweep");
        if (m_irr != 0) begin
          do_tpr(0);
          do_ack("R6 cleanup");
        end
        do_eoi();
        chk_state("R8 tpr sweep");
      end
    end
    do_tpr(0);

    // R8 end-of-interrupt with nothing in service, R7 again
    do_eoi();
    chk_state("R8 empty eoi");
    do_ack("R7 final");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule